// File: doc/BRIEF.md
# Host-to-Device Command/Data Mailbox

This block is a single 8-bit mailbox channel between a host processor and a local slave processor, of the kind used for keyboard-controller traffic. The host sends bytes with single-cycle I/O write strobes. A one-bit address select that comes with each write marks the byte as a command or as data. The byte goes into an input data register. A full flag is raised and is also driven out as an interrupt request to the slave. The slave takes the byte through its local bus, and that read clears the flag.

A status byte is visible to both sides. It carries the input-full flag, the command/data tag and a set of general-purpose bits that the slave owns. For the reverse direction, the slave loads an output data register, which raises an output-full flag. A host data read returns that byte and clears the flag.

Top module: `host_cmd_mailbox`

## Requirements
- R1: After reset every status bit is 0, the slave interrupt is low, and the input and output data registers hold 0.
- R2: A host write stores `host_wdata` into the input data register, which the slave sees on `slv_idr`. On the next clock, input-buffer-full (status bit 1) reads 1.
- R3: On every host write, `host_sel` is captured into status bit 3 (1 = command, 0 = data). No other action changes this bit.
- R4: Input-buffer-full clears only on a slave read of the input data register (`slv_rd_idr`). Host status reads, slave status writes and slave output writes leave it set.
- R5: When a host write and a slave input read occur in the same cycle, input-buffer-full ends at 1 and the new byte is kept.
- R6: `slv_irq` is high exactly while input-buffer-full is 1.
- R7: A slave status write (`slv_wr_status`) loads only the user bits 2, 4, 5, 6 and 7 from `slv_wdata`. Bits 0, 1 and 3 ignore it.
- R8: A host read with `host_sel`=1 returns the status byte on `host_rdata` and changes nothing. Host writes never alter the user bits.
- R9: A slave output write (`slv_wr_odr`) loads the output data register and sets output-buffer-full (status bit 0). A host read with `host_sel`=0 returns that byte in the same cycle and clears output-buffer-full.
- R10: When a slave output write and a host data read occur in the same cycle, the host receives the old byte, output-buffer-full ends at 1, and the new byte is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host I/O write strobe, one cycle |
| host_rd | input | 1 | Host I/O read strobe, one cycle |
| host_sel | input | 1 | Host address bit: 1 = status/command, 0 = data |
| host_wdata | input | DW | Host write byte |
| host_rdata | output | DW | Host read byte: status when `host_sel`=1, otherwise output data |
| slv_rd_idr | input | 1 | Slave read strobe for the input data register |
| slv_wr_odr | input | 1 | Slave write strobe for the output data register |
| slv_wr_status | input | 1 | Slave write strobe for the status user bits |
| slv_wdata | input | DW | Slave write byte |
| slv_idr | output | DW | Input data register contents |
| slv_status | output | DW | Status byte as seen by the slave |
| slv_irq | output | 1 | Interrupt request to the slave |

## Verification
The bench builds the block with the default DW=8. At that width every byte value can be swept through the input path twice, once tagged as data and once as a command, and the full byte range can also be pushed through the output register and the status-write path. The masking of the fixed flag positions is therefore checked against every possible write pattern. Directed same-cycle collisions on both flags cover the set-wins ordering.

// File: rtl/host_cmd_mailbox.sv
module host_cmd_mailbox #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic          host_sel,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          slv_rd_idr,
  input  logic          slv_wr_odr,
  input  logic          slv_wr_status,
  input  logic [DW-1:0] slv_wdata,
  output logic [DW-1:0] slv_idr,
  output logic [DW-1:0] slv_status,
  output logic          slv_irq
);
  localparam int OBF_B = 0;
  localparam int IBF_B = 1;
  localparam int CD_B  = 3;
  localparam logic [DW-1:0] USER_MASK = {{(DW-4){1'b1}}, 4'b0100};

  logic [DW-1:0] idr, odr, user;
  logic ibf, obf, cd;
  logic host_data_rd;

  assign host_data_rd = host_rd && !host_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idr <= '0;
      cd  <= 1'b0;
      ibf <= 1'b0;
    end else begin
      if (host_wr) begin
        idr <= host_wdata;
        cd  <= host_sel;
      end
      if (host_wr)         ibf <= 1'b1;
      else if (slv_rd_idr) ibf <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odr <= '0;
      obf <= 1'b0;
    end else begin
      if (slv_wr_odr) odr <= slv_wdata;
      if (slv_wr_odr)        obf <= 1'b1;
      else if (host_data_rd) obf <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             user <= '0;
    else if (slv_wr_status) user <= slv_wdata & USER_MASK;
  end

  always_comb begin
    slv_status        = user;
    slv_status[OBF_B] = obf;
    slv_status[IBF_B] = ibf;
    slv_status[CD_B]  = cd;
  end

  assign host_rdata = host_sel ? slv_status : odr;
  assign slv_idr    = idr;
  assign slv_irq    = ibf;

  a_r2_ibf_set: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> slv_status[IBF_B]);
  a_r4_ibf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (slv_status[IBF_B] && !slv_rd_idr) |=> slv_status[IBF_B]);
  a_r4_ibf_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (slv_rd_idr && !host_wr) |=> !slv_status[IBF_B]);
  a_r3_cd_capture: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> (slv_status[CD_B] == $past(host_sel)));
  a_r3_cd_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !host_wr |=> $stable(slv_status[CD_B]));
  a_r9_obf_set: assert property (@(posedge clk) disable iff (!rst_n)
    slv_wr_odr |=> slv_status[OBF_B]);
  a_r7_user_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !slv_wr_status |=> $stable(slv_status & USER_MASK));
  a_r6_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr |=> slv_irq));
endmodule

// File: tb/host_cmd_mailbox_tb_top.sv
module host_cmd_mailbox_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 0, host_rd = 0, host_sel = 0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic slv_rd_idr = 0, slv_wr_odr = 0, slv_wr_status = 0;
  logic [7:0] slv_wdata = '0;
  logic [7:0] slv_idr, slv_status;
  logic slv_irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] got;

  always #2.5 clk = ~clk;

  host_cmd_mailbox #(.DW(8)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_rd(host_rd), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .slv_rd_idr(slv_rd_idr), .slv_wr_odr(slv_wr_odr), .slv_wr_status(slv_wr_status),
    .slv_wdata(slv_wdata), .slv_idr(slv_idr), .slv_status(slv_status), .slv_irq(slv_irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] v, input logic sel);
    @(negedge clk); host_wr = 1; host_sel = sel; host_wdata = v;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic host_read(input logic sel, output logic [7:0] v);
    @(negedge clk); host_rd = 1; host_sel = sel;
    #1 v = host_rdata;
    @(negedge clk); host_rd = 0;
  endtask

  task automatic slv_read;
    @(negedge clk); slv_rd_idr = 1;
    @(negedge clk); slv_rd_idr = 0;
  endtask

  task automatic slv_odr(input logic [7:0] v);
    @(negedge clk); slv_wr_odr = 1; slv_wdata = v;
    @(negedge clk); slv_wr_odr = 0;
  endtask

  task automatic slv_stat(input logic [7:0] v);
    @(negedge clk); slv_wr_status = 1; slv_wdata = v;
    @(negedge clk); slv_wr_status = 0;
  endtask

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status", slv_status, 8'h00);
    chk("R1 irq", {7'b0, slv_irq}, 8'h00);
    chk("R1 idr", slv_idr, 8'h00);
    rst_n = 1;
    host_read(1'b0, got); chk("R1 odr", got, 8'h00);

    for (int s = 0; s < 2; s++) begin
      for (int v = 0; v < 256; v++) begin
        host_write(8'(v), 1'(s));
        chk("R2 idr", slv_idr, 8'(v));
        chk("R3 status", slv_status, (s != 0) ? 8'h0A : 8'h02);
        chk("R6 irq set", {7'b0, slv_irq}, 8'h01);
        host_read(1'b1, got);
        chk("R8 host status", got, (s != 0) ? 8'h0A : 8'h02);
        slv_read;
        chk("R4 ibf clear", slv_status, (s != 0) ? 8'h08 : 8'h00);
        chk("R6 irq clear", {7'b0, slv_irq}, 8'h00);
      end
    end

    host_write(8'h33, 1'b0);
    host_read(1'b1, got);
    chk("R4 after host status read", {7'b0, slv_status[1]}, 8'h01);
    slv_stat(8'h00);
    chk("R4 after status write", {7'b0, slv_status[1]}, 8'h01);
    slv_odr(8'h11);
    chk("R4 after odr write", {7'b0, slv_status[1]}, 8'h01);
    host_read(1'b0, got);
    chk("R9 odr read", got, 8'h11);
    chk("R9 obf cleared", {7'b0, slv_status[0]}, 8'h00);

    @(negedge clk); host_wr = 1; host_sel = 1; host_wdata = 8'h5A; slv_rd_idr = 1;
    @(negedge clk); host_wr = 0; slv_rd_idr = 0;
    chk("R5 ibf kept", {7'b0, slv_status[1]}, 8'h01);
    chk("R5 new byte", slv_idr, 8'h5A);
    slv_read;

    for (int v = 0; v < 256; v++) begin
      slv_stat(8'(v));
      chk("R7 user bits", slv_status, (8'(v) & 8'hF4) | 8'h08);
    end
    slv_stat(8'hA4);
    host_write(8'hFF, 1'b0);
    chk("R8 user kept", slv_status & 8'hF4, 8'hA4);
    slv_read;
    chk("R3 cd data", slv_status, 8'hA4);
    slv_stat(8'h00);

    for (int v = 0; v < 256; v++) begin
      slv_odr(8'(v));
      chk("R9 obf set", {7'b0, slv_status[0]}, 8'h01);
      host_read(1'b0, got);
      chk("R9 host data", got, 8'(v));
      chk("R9 obf clear", {7'b0, slv_status[0]}, 8'h00);
    end

    slv_odr(8'hC3);
    @(negedge clk); host_rd = 1; host_sel = 0; slv_wr_odr = 1; slv_wdata = 8'h3C;
    #1 got = host_rdata;
    @(negedge clk); host_rd = 0; slv_wr_odr = 0;
    chk("R10 old byte", got, 8'hC3);
    chk("R10 obf kept", {7'b0, slv_status[0]}, 8'h01);
    host_read(1'b0, got);
    chk("R10 new byte", got, 8'h3C);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule